// File: doc/BRIEF.md
# Latency-Guarded Dual-Policy Memory Arbiter

This block shares a single memory port among several requestors. Each request is tagged by its requestor as either critical (it must be served within a latency budget) or best-effort. Two grant policies live side by side. A throughput policy serves the request that has waited longest and does not look at the class tag. A real-time policy rotates among the critical requestors and lets best-effort traffic through only when no critical request waits. The arbiter starts in throughput mode and normally stays there.

A monitor counts, for every requestor, how long its pending critical request has been kept waiting. Each requestor has its own budget, and one global guard margin applies to all of them; both are set through a small write port. When any waiting critical request comes within the margin of its budget, the arbiter moves to real-time mode. It moves back as soon as no waiting critical request is that close. A mode change is applied only in a cycle with no transaction outstanding on the memory port. A sticky flag per requestor records which requestors caused an entry into real-time mode.

Top module: `lg_mem_arbiter`

## Requirements
- R1: After reset the arbiter is in throughput mode, all trigger flags are clear, every latency counter is zero, every budget is all ones, the margin is zero and no grant is issued while no request is valid.
- R2: At most one requestor is granted in any cycle. Only a valid requestor can be granted. No grant is issued from the grant cycle up to and including the cycle in which `mem_done` is high. The cycle after that is idle.
- R3: In the grant cycle, `mem_valid` is high, `mem_id` carries the binary index of the granted requestor, and `mem_crit` carries that requestor's class tag (1 = critical).
- R4: In throughput mode the grant goes to the valid requestor whose request has waited the most cycles. Ties go to the lowest index, and the class tag has no influence.
- R5: A requestor's latency counter rises by one in each cycle in which its critical request is valid and not granted. It saturates at all ones and does not wrap. It returns to zero when the request is granted or withdrawn.
- R6: A requestor is over budget when its critical request is valid and its counter plus the margin is at least its budget. An idle cycle with any requestor over budget selects real-time mode. An entry from throughput mode also sets the sticky flag of every requestor that is over budget in that cycle. The flags then stay set until reset.
- R7: An idle cycle in which no requestor is over budget selects throughput mode.
- R8: The mode is re-evaluated only in idle cycles, and the new mode takes effect in the following cycle. While a transaction is outstanding the mode does not change, even if a budget is crossed.
- R9: In real-time mode, while any critical request is valid, the grant goes to the first critical requestor found by searching upward (with wrap-around) from the index after the most recently granted requestor, counting grants made in either mode. Only when no critical request is valid does a best-effort request win, chosen as in R4.
- R10: A cycle with `cfg_wr` high writes `cfg_budget` into the budget of requestor `cfg_sel`. A cycle with `cfg_margin_wr` high writes `cfg_margin` into the margin. Both take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_REQ | Per-requestor request present |
| req_crit | input | N_REQ | Per-requestor class tag, 1 = critical |
| req_ready | output | N_REQ | One-hot grant, request accepted this cycle |
| mem_valid | output | 1 | A transaction is issued to memory this cycle |
| mem_id | output | clog2(N_REQ) | Index of the granted requestor |
| mem_crit | output | 1 | Class tag of the granted request |
| mem_done | input | 1 | Outstanding memory transaction completes this cycle |
| cfg_wr | input | 1 | Budget write strobe |
| cfg_sel | input | clog2(N_REQ) | Requestor whose budget is written |
| cfg_budget | input | LAT_W | Budget value |
| cfg_margin_wr | input | 1 | Margin write strobe |
| cfg_margin | input | LAT_W | Guard margin value |
| mode_rt | output | 1 | 1 while the real-time policy is active |
| trig_flags | output | N_REQ | Sticky flags of requestors that caused a real-time entry |

## Verification
The hardest state to reach is a stay in real-time mode that lasts several transactions. Every grant clears the counter of the requestor it serves, so the mode drops back unless some other critical request keeps waiting across each idle boundary. The bench gets there by setting one-cycle budgets on two critical requestors that request continuously, while best-effort requests wait behind them. It then checks each grant against the rotation rule. A second difficulty is a budget crossing in the middle of a long transaction. A sweep over budget, margin and transaction length holds the port busy while a critical request waits, then checks that the mode flips only after the port goes idle. It also runs long enough to reach counter saturation.

// File: rtl/lg_arb_pkg.sv
package lg_arb_pkg;
    typedef enum logic {
        MODE_PERF = 1'b0,
        MODE_RT   = 1'b1
    } arb_mode_e;
endpackage

// File: rtl/lg_lat_monitor.sv
module lg_lat_monitor #(
    parameter int N_REQ = 4,
    parameter int LAT_W = 8,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] pend_crit,
    input  logic [N_REQ-1:0] granted,
    input  logic             cfg_wr,
    input  logic [IDX_W-1:0] cfg_sel,
    input  logic [LAT_W-1:0] cfg_budget,
    input  logic             cfg_margin_wr,
    input  logic [LAT_W-1:0] cfg_margin,
    output logic [N_REQ-1:0] over
);
    localparam logic [LAT_W-1:0] LAT_MAX = '1;

    typedef struct packed {
        logic [N_REQ-1:0][LAT_W-1:0] lat;
        logic [N_REQ-1:0][LAT_W-1:0] budget;
        logic [LAT_W-1:0]            margin;
    } mon_t;

    mon_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N_REQ; i++) begin
            if (granted[i] || !pend_crit[i])
                st_d.lat[i] = '0;
            else if (st_q.lat[i] != LAT_MAX)
                st_d.lat[i] = st_q.lat[i] + 1'b1;
        end
        if (cfg_wr)
            st_d.budget[cfg_sel] = cfg_budget;
        if (cfg_margin_wr)
            st_d.margin = cfg_margin;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.lat    <= '0;
            st_q.budget <= '1;
            st_q.margin <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < N_REQ; g++) begin : g_cmp
        assign over[g] = pend_crit[g] &&
            (({1'b0, st_q.lat[g]} + {1'b0, st_q.margin}) >= {1'b0, st_q.budget[g]});

        AST_LAT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_crit[g] && !granted[g] && st_q.lat[g] == LAT_MAX) |=> (st_q.lat[g] == LAT_MAX)); // R5
        AST_LAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            granted[g] |=> (st_q.lat[g] == '0)); // R5
    end
endmodule

// File: rtl/lg_perf_arb.sv
module lg_perf_arb #(
    parameter int N_REQ = 4,
    parameter int AGE_W = 6,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] valid,
    input  logic [N_REQ-1:0] granted,
    output logic [N_REQ-1:0] pick_oh
);
    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    typedef struct packed {
        logic [N_REQ-1:0][AGE_W-1:0] age;
    } perf_t;

    perf_t            st_d, st_q;
    logic             found;
    logic [AGE_W-1:0] best;
    logic [IDX_W-1:0] sel;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N_REQ; i++) begin
            if (!valid[i] || granted[i])
                st_d.age[i] = '0;
            else if (st_q.age[i] != AGE_MAX)
                st_d.age[i] = st_q.age[i] + 1'b1;
        end
    end

    always_comb begin
        pick_oh = '0;
        found   = 1'b0;
        best    = '0;
        sel     = '0;
        for (int i = 0; i < N_REQ; i++) begin
            if (valid[i] && (!found || st_q.age[i] > best)) begin
                found = 1'b1;
                best  = st_q.age[i];
                sel   = IDX_W'(i);
            end
        end
        if (found)
            pick_oh[sel] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    AST_PERF_SERVES: assert property (@(posedge clk) disable iff (!rst_n)
        (|valid) |-> ((pick_oh & valid) != '0)); // R4
endmodule

// File: rtl/lg_rt_arb.sv
module lg_rt_arb #(
    parameter int N_REQ = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] crit_pend,
    input  logic             advance,
    input  logic [IDX_W-1:0] gnt_idx,
    output logic [N_REQ-1:0] pick_oh,
    output logic             any_crit
);
    typedef struct packed {
        logic [IDX_W-1:0] rr;
    } rt_t;

    rt_t            st_d, st_q;
    logic           found;
    logic [IDX_W:0] idx;

    always_comb begin
        st_d = st_q;
        if (advance)
            st_d.rr = (gnt_idx == IDX_W'(N_REQ - 1)) ? '0 : gnt_idx + 1'b1;
    end

    always_comb begin
        pick_oh = '0;
        found   = 1'b0;
        idx     = '0;
        for (int k = 0; k < N_REQ; k++) begin
            idx = {1'b0, st_q.rr} + (IDX_W + 1)'(k);
            if (idx >= (IDX_W + 1)'(N_REQ))
                idx = idx - (IDX_W + 1)'(N_REQ);
            if (!found && crit_pend[idx[IDX_W-1:0]]) begin
                found = 1'b1;
                pick_oh[idx[IDX_W-1:0]] = 1'b1;
            end
        end
        any_crit = found;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    AST_RT_PICK_CRIT: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_oh & ~crit_pend) == '0); // R9
endmodule

// File: rtl/lg_mem_arbiter.sv
module lg_mem_arbiter
    import lg_arb_pkg::*;
#(
    parameter int N_REQ = 4,
    parameter int LAT_W = 8,
    parameter int AGE_W = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_REQ-1:0]           req_valid,
    input  logic [N_REQ-1:0]           req_crit,
    output logic [N_REQ-1:0]           req_ready,
    output logic                       mem_valid,
    output logic [$clog2(N_REQ)-1:0]   mem_id,
    output logic                       mem_crit,
    input  logic                       mem_done,
    input  logic                       cfg_wr,
    input  logic [$clog2(N_REQ)-1:0]   cfg_sel,
    input  logic [LAT_W-1:0]           cfg_budget,
    input  logic                       cfg_margin_wr,
    input  logic [LAT_W-1:0]           cfg_margin,
    output logic                       mode_rt,
    output logic [N_REQ-1:0]           trig_flags
);
    localparam int IDX_W = $clog2(N_REQ);

    typedef struct packed {
        logic             busy;
        arb_mode_e        mode;
        logic [N_REQ-1:0] flags;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic [N_REQ-1:0] pend_crit;
    logic [N_REQ-1:0] over;
    logic [N_REQ-1:0] perf_pick;
    logic [N_REQ-1:0] rt_pick;
    logic             rt_any;
    logic [N_REQ-1:0] pick;
    logic [N_REQ-1:0] gnt;
    logic [IDX_W-1:0] gnt_idx;

    assign pend_crit = req_valid & req_crit;

    lg_lat_monitor #(.N_REQ(N_REQ), .LAT_W(LAT_W), .IDX_W(IDX_W)) u_mon (
        .clk           (clk),
        .rst_n         (rst_n),
        .pend_crit     (pend_crit),
        .granted       (gnt),
        .cfg_wr        (cfg_wr),
        .cfg_sel       (cfg_sel),
        .cfg_budget    (cfg_budget),
        .cfg_margin_wr (cfg_margin_wr),
        .cfg_margin    (cfg_margin),
        .over          (over)
    );

    lg_perf_arb #(.N_REQ(N_REQ), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_perf (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (req_valid),
        .granted (gnt),
        .pick_oh (perf_pick)
    );

    lg_rt_arb #(.N_REQ(N_REQ), .IDX_W(IDX_W)) u_rt (
        .clk       (clk),
        .rst_n     (rst_n),
        .crit_pend (pend_crit),
        .advance   (|gnt),
        .gnt_idx   (gnt_idx),
        .pick_oh   (rt_pick),
        .any_crit  (rt_any)
    );

    always_comb begin
        ctl_d = ctl_q;
        pick  = ((ctl_q.mode == MODE_RT) && rt_any) ? rt_pick : perf_pick;
        gnt   = ctl_q.busy ? '0 : pick;
        gnt_idx = '0;
        for (int i = 0; i < N_REQ; i++) begin
            if (gnt[i])
                gnt_idx = IDX_W'(i);
        end
        if (ctl_q.busy) begin
            ctl_d.busy = !mem_done;
        end else begin
            ctl_d.busy = |gnt;
            ctl_d.mode = (|over) ? MODE_RT : MODE_PERF;
            if ((ctl_q.mode == MODE_PERF) && (|over))
                ctl_d.flags = ctl_q.flags | over;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= '{busy: 1'b0, mode: MODE_PERF, flags: '0};
        else
            ctl_q <= ctl_d;
    end

    assign req_ready  = gnt;
    assign mem_valid  = |gnt;
    assign mem_id     = gnt_idx;
    assign mem_crit   = |(gnt & req_crit);
    assign mode_rt    = (ctl_q.mode == MODE_RT);
    assign trig_flags = ctl_q.flags;

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready)); // R2
    AST_GRANT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready & ~req_valid) == '0); // R2
    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |=> !mem_valid); // R2
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.busy |=> (ctl_q.mode == $past(ctl_q.mode))); // R8
    AST_RT_CRIT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_rt && (|pend_crit) && mem_valid) |-> mem_crit); // R9
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (|trig_flags) |=> ((trig_flags & $past(trig_flags)) == $past(trig_flags))); // R6
    AST_ENTRY_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_rt) |-> (|trig_flags)); // R6
endmodule

// File: tb/lg_mem_arbiter_tb.sv
`timescale 1ns/100ps
module lg_mem_arbiter_tb;
    localparam int N     = 4;
    localparam int LAT_W = 5;
    localparam int LMAX  = 31;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   req_valid = '0;
    logic [N-1:0]   req_crit = '0;
    logic [N-1:0]   req_ready;
    logic           mem_valid;
    logic [1:0]     mem_id;
    logic           mem_crit;
    logic           mem_done = 1'b0;
    logic           cfg_wr = 1'b0;
    logic [1:0]     cfg_sel = '0;
    logic [LAT_W-1:0] cfg_budget = '0;
    logic           cfg_margin_wr = 1'b0;
    logic [LAT_W-1:0] cfg_margin = '0;
    logic           mode_rt;
    logic [N-1:0]   trig_flags;

    int n_checks = 0;
    int n_errs   = 0;

    always #2.5 clk = ~clk;

    lg_mem_arbiter #(.N_REQ(N), .LAT_W(LAT_W), .AGE_W(6)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_crit(req_crit),
        .req_ready(req_ready), .mem_valid(mem_valid), .mem_id(mem_id),
        .mem_crit(mem_crit), .mem_done(mem_done), .cfg_wr(cfg_wr),
        .cfg_sel(cfg_sel), .cfg_budget(cfg_budget), .cfg_margin_wr(cfg_margin_wr),
        .cfg_margin(cfg_margin), .mode_rt(mode_rt), .trig_flags(trig_flags)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        cfg_wr = 1'b0;
        cfg_margin_wr = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req_valid = '0; req_crit = '0; mem_done = 1'b0;
        cfg_wr = 1'b0; cfg_margin_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic int oh_idx(input logic [N-1:0] v);
        int r = -1;
        for (int i = 0; i < N; i++) if (v[i]) r = i;
        return r;
    endfunction

    // Budget / margin / transaction-length sweep on requestor 1 (R5 R6 R7 R8 R10)
    task automatic run_sweep(input int b, input int m, input int h, input bit wr);
        int  lat_exp;
        bit  exp_rt;
        logic [N-1:0] exp_fl;
        do_reset();
        if (wr) begin
            step(); cfg_wr = 1'b1; cfg_sel = 2'd1; cfg_budget = LAT_W'(b);
        end
        step(); cfg_margin_wr = 1'b1; cfg_margin = LAT_W'(m);
        lat_exp = (h + 1 > LMAX) ? LMAX : h + 1;
        exp_rt  = (lat_exp + m >= b);
        exp_fl  = exp_rt ? 4'b0010 : 4'b0000;
        step(); req_valid = 4'b0011; req_crit = 4'b0010; #1;
        chk(req_ready == 4'b0001 && mem_id == 2'd0, "R4 tie to lowest index", int'(req_ready), 1);
        for (int k = 1; k <= h; k++) begin
            step(); req_valid = 4'b0010; mem_done = (k == h); #1;
            chk(req_ready == '0, "R2 no grant while outstanding", int'(req_ready), 0);
            chk(mode_rt == 1'b0, "R8 mode held while busy", int'(mode_rt), 0);
        end
        step(); mem_done = 1'b0; #1;
        chk(req_ready == 4'b0010 && mem_id == 2'd1 && mem_crit, "R3 id and class", int'(mem_id), 1);
        chk(mode_rt == 1'b0, "R8 change not yet visible", int'(mode_rt), 0);
        step(); req_valid = '0; mem_done = 1'b1; #1;
        chk(mode_rt == exp_rt, "R6 R5 R10 entry decision", int'(mode_rt), int'(exp_rt));
        chk(trig_flags == exp_fl, "R6 trigger flag", int'(trig_flags), int'(exp_fl));
        step(); mem_done = 1'b0; #1;
        chk(mode_rt == exp_rt, "R8 held across busy cycle", int'(mode_rt), int'(exp_rt));
        step(); #1;
        chk(mode_rt == 1'b0, "R7 return to throughput", int'(mode_rt), 0);
        chk(trig_flags == exp_fl, "R6 flag sticky", int'(trig_flags), int'(exp_fl));
    endtask

    // Throughput ordering by arrival (R2 R3 R4)
    task automatic run_order(input int arr [N], input bit crt [N]);
        bit served [N];
        bit used [N];
        int got [N];
        int cnt = 0;
        int done_at = -1;
        bit outst = 1'b0;
        int g;
        do_reset();
        for (int i = 0; i < N; i++) begin served[i] = 1'b0; used[i] = 1'b0; got[i] = -1; end
        for (int cyc = 0; cyc < 20; cyc++) begin
            step();
            for (int i = 0; i < N; i++) begin
                req_valid[i] = (cyc >= arr[i]) && !served[i];
                req_crit[i]  = crt[i];
            end
            mem_done = (cyc == done_at);
            #1;
            if (req_ready != '0) begin
                g = oh_idx(req_ready);
                chk(!outst, "R2 grant during transaction", 1, 0);
                chk($onehot(req_ready) && req_valid[g], "R2 one valid grant", int'(req_ready), 0);
                chk(mem_valid && mem_id == 2'(g) && mem_crit == crt[g], "R3 port fields", int'(mem_id), g);
                if (cnt < N) got[cnt] = g;
                cnt++;
                served[g] = 1'b1;
                outst = 1'b1;
                done_at = (cnt == 1) ? 4 : cyc + 1;
            end
            if (cyc == done_at) outst = 1'b0;
        end
        chk(cnt == N, "R4 all served", cnt, N);
        for (int r = 0; r < N; r++) begin
            int best = -1;
            for (int i = 0; i < N; i++)
                if (!used[i] && (best < 0 || arr[i] < arr[best])) best = i;
            used[best] = 1'b1;
            chk(got[r] == best, "R4 oldest first", got[r], best);
        end
    endtask

    // Sustained real-time mode (R6 R7 R9)
    task automatic run_rt();
        int last = N - 1;
        int rt_cnt = 0;
        int c0 = -1, c1 = -1;
        int done_at = -1;
        bit outst = 1'b0;
        int g, e;
        logic [N-1:0] cp;
        do_reset();
        step(); cfg_wr = 1'b1; cfg_sel = 2'd2; cfg_budget = 5'd1;
        step(); cfg_wr = 1'b1; cfg_sel = 2'd3; cfg_budget = 5'd1;
        for (int cyc = 0; cyc < 70; cyc++) begin
            step();
            req_crit = 4'b1100;
            req_valid[3] = (cyc < 40);
            req_valid[2] = (cyc < 30);
            req_valid[0] = (cyc >= 5) && (c0 < 0);
            req_valid[1] = (cyc >= 8) && (c1 < 0);
            mem_done = (cyc == done_at);
            #1;
            if (req_ready != '0) begin
                g = oh_idx(req_ready);
                chk(!outst, "R2 grant during transaction", 1, 0);
                chk(mem_id == 2'(g) && mem_crit == req_crit[g], "R3 port fields", int'(mem_id), g);
                cp = req_valid & req_crit;
                if (mode_rt && cp != '0) begin
                    e = -1;
                    for (int k = 1; k <= N; k++)
                        if (e < 0 && cp[(last + k) % N]) e = (last + k) % N;
                    chk(g == e, "R9 rotation among critical", g, e);
                    rt_cnt++;
                end
                last = g;
                if (g == 0) c0 = cyc;
                if (g == 1) c1 = cyc;
                outst = 1'b1;
                done_at = cyc + 1;
            end
            if (cyc == done_at) outst = 1'b0;
        end
        chk(rt_cnt >= 10, "R6 real-time mode sustained", rt_cnt, 10);
        chk(c0 >= 40, "R9 best-effort held off", c0, 40);
        chk(c1 > c0, "R9 best-effort oldest first", c1, c0 + 1);
        chk(mode_rt == 1'b0, "R7 back to throughput", int'(mode_rt), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errs++;
        n_checks++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        do_reset();
        step(); #1;
        chk(mode_rt == 1'b0, "R1 reset mode", int'(mode_rt), 0);
        chk(trig_flags == '0, "R1 reset flags", int'(trig_flags), 0);
        chk(req_ready == '0 && !mem_valid, "R1 no grant", int'(req_ready), 0);

        for (int b = 3; b <= 8; b++)
            for (int m = 0; m <= 2; m++)
                for (int h = 1; h <= 6; h++)
                    run_sweep(b, m, h, 1'b1);
        run_sweep(LMAX, 0, 29, 1'b0);   // R10 default budget not reached
        run_sweep(LMAX, 0, 30, 1'b0);   // R10 default budget reached
        run_sweep(LMAX, 0, 40, 1'b1);   // R5 saturation, wrap would miss

        for (int s = 0; s < N; s++) begin
            int a [N];
            bit c [N];
            for (int i = 0; i < N; i++) begin
                a[i] = (i + s) % N;
                c[i] = (i % 2 == 1);
            end
            run_order(a, c);
        end
        run_order('{0, 1, 2, 1}, '{1'b0, 1'b0, 1'b1, 1'b1});
        run_order('{0, 2, 1, 3}, '{1'b1, 1'b1, 1'b0, 1'b1});

        run_rt();

        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule